// File: doc/BRIEF.md
# Frame-Restarted Program Fetch Controller

This block feeds instruction words to a small signal processor whose program lives in a flash shared with a host processor. At the beginning of every multiplexer frame, marked by a one-cycle `frame_start` pulse, the controller samples a 5-bit program location value. It then sets the program base to 1024 bytes times that value and restarts the fetch counter at zero. From the next cycle on it requests one 16-bit word per cycle at successive even byte addresses. Each returned word is presented to the execution side together with its index within the program.

A pass ends normally when a word carrying the halt opcode is presented. It ends abnormally when 1024 words have been fetched without one; in that case a sticky limit error is raised. If a new frame begins while a pass is still running, a sticky overrun flag is set and the pass restarts from the newly sampled location. The host shares the single flash read port. The engine always wins a conflict, and the host request waits on a ready handshake. Read data reaches the requester one cycle after its request.

Top module: `prog_fetch_ctrl`

## Requirements
- R1: After reset, `busy`, `pass_done`, `instr_valid`, `overrun`, `limit_err` and `host_rvalid` are low, and `flash_req` is low while `host_req` is low.
- R2: A `frame_start` pulse sampled at a clock edge makes `busy` high in the following cycle, and in that cycle the first fetch goes out at byte address `prog_loc`*1024.
- R3: Word n of a pass is requested in the (n+1)th cycle after the start edge at byte address base+2n. In the next cycle `instr_valid` is high with `instr_pc`=n and `instr_word` equal to the flash word at that address.
- R4: `prog_loc` is sampled only on the `frame_start` edge. Changing it during a pass does not move the fetch addresses of that pass.
- R5: A presented word whose bits [15:12] equal 4'hF is the halt word. `pass_done` is high in the cycle it is presented. In the next cycle `busy`, `instr_valid` and `pass_done` are low, and the word fetched during the halt cycle is never presented.
- R6: A pass fetches at most 1024 words. If word 1023 is not a halt, `busy` drops after it is presented and `limit_err` rises and stays high until reset. A halt at word 1023 ends the pass with `limit_err` low.
- R7: A `frame_start` sampled while `busy` is high and `pass_done` is low sets `overrun`, which stays high until reset. The pass restarts from the new `prog_loc`, and no word is presented in the cycle after that edge. A start from idle leaves `overrun` unchanged.
- R8: `host_ready` is high exactly when `host_req` is high and the engine is not fetching. The engine fetches in every `busy` cycle until 1024 words have been requested. While `host_ready` is high, `flash_req` is high and `flash_addr` equals `host_addr`.
- R9: `host_rvalid` is high exactly in the cycle after a cycle with `host_ready` high, and `host_rdata` then carries the flash word read for the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Pulse marking the start of multiplexer state 0 |
| prog_loc | input | 5 | Program location; base byte address = value*1024 |
| host_req | input | 1 | Host read request, held until granted |
| host_addr | input | 16 | Host byte address |
| host_ready | output | 1 | Host request granted this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 16 | Host read data |
| flash_req | output | 1 | Flash read strobe |
| flash_addr | output | 16 | Flash byte address |
| flash_rdata | input | 16 | Flash data, one cycle after the strobe |
| instr_valid | output | 1 | Instruction word presented |
| instr_pc | output | 10 | Word index of the presented word within the pass |
| instr_word | output | 16 | Presented instruction word |
| pass_done | output | 1 | Halt word presented; pass complete |
| busy | output | 1 | Pass in progress |
| overrun | output | 1 | Sticky: new frame began before the pass finished |
| limit_err | output | 1 | Sticky: 1024 words fetched with no halt |

## Verification
Some properties are checked on every cycle. The host is never granted while the engine fetches, and a grant always routes the host address with read data one cycle later. A presented word always lies inside a pass, and a halt closes the pass on the next edge. The start edge raises `busy`, and both error flags are sticky. Other behaviours can only be shown by the bench's scenarios. These are the exact address sequence from a chosen base, the word index and contents at each step, where the halt lands, the 1024-word cutoff, the restart from a new location on overrun, and the cycle at which a waiting host is finally served.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   typedef enum logic {
      PS_IDLE = 1'b0,
      PS_RUN  = 1'b1
   } pass_st_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pfc_addr_gen.sv
module pfc_addr_gen #(
   parameter int LOC_W     = 5,
   parameter int BOUND_LG  = 10,
   parameter int IDX_W     = 10,
   parameter int PC_W      = 11,
   parameter int FA_W      = 16,
   parameter int MAX_WORDS = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LOC_W-1:0] loc,
   input  logic             advance,
   output logic [IDX_W-1:0] pc_idx,
   output logic             at_limit,
   output logic [FA_W-1:0]  fetch_addr
);

   logic [LOC_W-1:0] base_q;
   logic [PC_W-1:0]  pc_q;

   // base is latched only on the frame edge; pc counts issued words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         pc_q   <= '0;
      end else if (start) begin
         base_q <= loc;
         pc_q   <= '0;
      end else if (advance) begin
         pc_q   <= pc_q + PC_W'(1);
      end
   end

   assign at_limit   = (pc_q == PC_W'(MAX_WORDS));
   assign pc_idx     = pc_q[IDX_W-1:0];
   assign fetch_addr = (FA_W'(base_q) << BOUND_LG) + (FA_W'(pc_q) << 1);

endmodule

// File: rtl/pfc_pass_fsm.sv
module pfc_pass_fsm
   import pfc_pkg::*;
#(
   parameter int                WORD_W    = 16,
   parameter int                IDX_W     = 10,
   parameter int                MAX_WORDS = 1024,
   parameter logic [WORD_W-1:0] HALT_CODE = 16'hF000,
   parameter logic [WORD_W-1:0] HALT_MASK = 16'hF000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              at_limit,
   input  logic [IDX_W-1:0]  pc_idx,
   input  logic [WORD_W-1:0] rsp_word,
   output logic              run,
   output logic              issue,
   output logic              rsp_v,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic              halt_seen,
   output logic              overrun,
   output logic              limit_err
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_WORDS - 1);

   pass_st_t st_q, st_d;
   logic     is_halt;
   logic     lim_end;

   generate
      if (HALT_MASK == {WORD_W{1'b1}}) begin : g_halt_exact
         assign is_halt = (rsp_word == HALT_CODE);
      end else begin : g_halt_field
         assign is_halt = ((rsp_word & HALT_MASK) == (HALT_CODE & HALT_MASK));
      end
   endgenerate

   assign run       = (st_q == PS_RUN);
   assign issue     = run && !at_limit;
   assign halt_seen = rsp_v && is_halt;
   assign lim_end   = rsp_v && !is_halt && (rsp_idx == LAST_IDX);

   always_comb begin
      st_d = st_q;
      if (start)
         st_d = PS_RUN;
      else if (halt_seen || lim_end)
         st_d = PS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PS_IDLE;
         rsp_v     <= 1'b0;
         rsp_idx   <= '0;
         overrun   <= 1'b0;
         limit_err <= 1'b0;
      end else begin
         st_q <= st_d;
         // the fetch issued in a halt or restart cycle is dropped
         rsp_v <= issue && !halt_seen && !start;
         if (issue)
            rsp_idx <= pc_idx;
         if (start && run && !halt_seen)
            overrun <= 1'b1;
         if (lim_end)
            limit_err <= 1'b1;
      end
   end

endmodule

// File: rtl/pfc_flash_arb.sv
module pfc_flash_arb #(
   parameter int FA_W           = 16,
   parameter int WORD_W         = 16,
   parameter bit HOLD_HOST_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_issue,
   input  logic [FA_W-1:0]   eng_addr,
   input  logic              host_req,
   input  logic [FA_W-1:0]   host_addr,
   input  logic [WORD_W-1:0] flash_rdata,
   output logic              flash_req,
   output logic [FA_W-1:0]   flash_addr,
   output logic              host_ready,
   output logic              host_rvalid,
   output logic [WORD_W-1:0] host_rdata
);

   // engine owns the port whenever it fetches; host waits
   assign host_ready = host_req && !eng_issue;
   assign flash_req  = eng_issue || host_req;
   assign flash_addr = eng_issue ? eng_addr : host_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         host_rvalid <= 1'b0;
      else
         host_rvalid <= host_ready;
   end

   generate
      if (HOLD_HOST_DATA) begin : g_hold
         logic [WORD_W-1:0] held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held_q <= '0;
            else if (host_rvalid)
               held_q <= flash_rdata;
         end
         assign host_rdata = host_rvalid ? flash_rdata : held_q;
      end else begin : g_pass
         assign host_rdata = flash_rdata;
      end
   endgenerate

endmodule

// File: rtl/prog_fetch_ctrl.sv
module prog_fetch_ctrl
   import pfc_pkg::*;
#(
   parameter int                LOC_W          = 5,
   parameter int                WORD_W         = 16,
   parameter int                BOUND_BYTES    = 1024,
   parameter int                MAX_WORDS      = 1024,
   parameter logic [WORD_W-1:0] HALT_CODE      = 16'hF000,
   parameter logic [WORD_W-1:0] HALT_MASK      = 16'hF000,
   parameter bit                HOLD_HOST_DATA = 1'b0,
   localparam int BOUND_LG = $clog2(BOUND_BYTES),
   localparam int IDX_W    = $clog2(MAX_WORDS),
   localparam int PC_W     = IDX_W + 1,
   localparam int SPAN_A   = LOC_W + BOUND_LG,
   localparam int SPAN_B   = IDX_W + 1,
   localparam int FA_W     = ((SPAN_A > SPAN_B) ? SPAN_A : SPAN_B) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [LOC_W-1:0]  prog_loc,
   input  logic              host_req,
   input  logic [FA_W-1:0]   host_addr,
   output logic              host_ready,
   output logic              host_rvalid,
   output logic [WORD_W-1:0] host_rdata,
   output logic              flash_req,
   output logic [FA_W-1:0]   flash_addr,
   input  logic [WORD_W-1:0] flash_rdata,
   output logic              instr_valid,
   output logic [IDX_W-1:0]  instr_pc,
   output logic [WORD_W-1:0] instr_word,
   output logic              pass_done,
   output logic              busy,
   output logic              overrun,
   output logic              limit_err
);

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("prog_fetch_ctrl: words must be two bytes wide");
      end
      if (!is_pow2(BOUND_BYTES) || BOUND_BYTES < 2) begin : g_bad_bound
         $error("prog_fetch_ctrl: location boundary must be a power of two");
      end
      if (!is_pow2(MAX_WORDS) || MAX_WORDS < 2) begin : g_bad_max
         $error("prog_fetch_ctrl: word limit must be a power of two");
      end
      if (LOC_W < 1) begin : g_bad_loc
         $error("prog_fetch_ctrl: location width must be positive");
      end
   endgenerate

   logic             eng_issue;
   logic             at_limit;
   logic [IDX_W-1:0] pc_idx;
   logic [FA_W-1:0]  eng_addr;
   logic             rsp_v;
   logic [IDX_W-1:0] rsp_idx;
   logic             halt_seen;
   logic             run;

   pfc_addr_gen #(
      .LOC_W(LOC_W), .BOUND_LG(BOUND_LG), .IDX_W(IDX_W),
      .PC_W(PC_W), .FA_W(FA_W), .MAX_WORDS(MAX_WORDS)
   ) addr_i (
      .clk(clk), .rst_n(rst_n), .start(frame_start), .loc(prog_loc),
      .advance(eng_issue), .pc_idx(pc_idx), .at_limit(at_limit),
      .fetch_addr(eng_addr)
   );

   pfc_pass_fsm #(
      .WORD_W(WORD_W), .IDX_W(IDX_W), .MAX_WORDS(MAX_WORDS),
      .HALT_CODE(HALT_CODE), .HALT_MASK(HALT_MASK)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n), .start(frame_start), .at_limit(at_limit),
      .pc_idx(pc_idx), .rsp_word(flash_rdata), .run(run), .issue(eng_issue),
      .rsp_v(rsp_v), .rsp_idx(rsp_idx), .halt_seen(halt_seen),
      .overrun(overrun), .limit_err(limit_err)
   );

   pfc_flash_arb #(
      .FA_W(FA_W), .WORD_W(WORD_W), .HOLD_HOST_DATA(HOLD_HOST_DATA)
   ) arb_i (
      .clk(clk), .rst_n(rst_n), .eng_issue(eng_issue), .eng_addr(eng_addr),
      .host_req(host_req), .host_addr(host_addr), .flash_rdata(flash_rdata),
      .flash_req(flash_req), .flash_addr(flash_addr), .host_ready(host_ready),
      .host_rvalid(host_rvalid), .host_rdata(host_rdata)
   );

   assign busy        = run;
   assign instr_valid = rsp_v;
   assign instr_pc    = rsp_idx;
   assign instr_word  = flash_rdata;
   assign pass_done   = halt_seen;

endmodule

// File: rtl/prog_fetch_ctrl_chk.sv
module prog_fetch_ctrl_chk #(
   parameter int FA_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            frame_start,
   input logic            host_req,
   input logic [FA_W-1:0] host_addr,
   input logic            host_ready,
   input logic            host_rvalid,
   input logic            flash_req,
   input logic [FA_W-1:0] flash_addr,
   input logic            instr_valid,
   input logic            pass_done,
   input logic            busy,
   input logic            overrun,
   input logic            limit_err
);

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> busy && !instr_valid);

   assert_instr_in_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |-> busy);

   assert_halt_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_done && !frame_start) |=> (!busy && !instr_valid));

   assert_limit_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      limit_err |=> limit_err);

   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && busy && !pass_done) |=> overrun);

   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   assert_host_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (flash_req && flash_addr == host_addr));

   assert_host_idle_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !busy) |-> host_ready);

   assert_fetch_in_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_req && !host_ready) |-> busy);

   assert_host_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |=> host_rvalid);

   assert_host_no_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ready |=> !host_rvalid);

endmodule

bind prog_fetch_ctrl prog_fetch_ctrl_chk #(.FA_W(FA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .host_req(host_req),
   .host_addr(host_addr), .host_ready(host_ready), .host_rvalid(host_rvalid),
   .flash_req(flash_req), .flash_addr(flash_addr), .instr_valid(instr_valid),
   .pass_done(pass_done), .busy(busy), .overrun(overrun), .limit_err(limit_err)
);

// File: tb/prog_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module prog_fetch_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic [4:0]  prog_loc = '0;
   logic        host_req = 1'b0;
   logic [15:0] host_addr = '0;
   logic        host_ready, host_rvalid;
   logic [15:0] host_rdata;
   logic        flash_req;
   logic [15:0] flash_addr;
   logic [15:0] flash_rdata = '0;
   logic        instr_valid;
   logic [9:0]  instr_pc;
   logic [15:0] instr_word;
   logic        pass_done, busy, overrun, limit_err;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [15:0] halt_a = 16'hFFFF;

   always #2 clk = ~clk;

   prog_fetch_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .prog_loc(prog_loc),
      .host_req(host_req), .host_addr(host_addr), .host_ready(host_ready),
      .host_rvalid(host_rvalid), .host_rdata(host_rdata), .flash_req(flash_req),
      .flash_addr(flash_addr), .flash_rdata(flash_rdata), .instr_valid(instr_valid),
      .instr_pc(instr_pc), .instr_word(instr_word), .pass_done(pass_done),
      .busy(busy), .overrun(overrun), .limit_err(limit_err)
   );

   // flash content: halt word (top nibble F) only at halt_a, else top bit 0
   function automatic logic [15:0] word_at(input logic [15:0] a);
      return (a == halt_a) ? {4'hF, a[11:0]} : {1'b0, a[15:1]};
   endfunction

   always @(posedge clk) if (flash_req) flash_rdata <= word_at(flash_addr);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; frame_start = 1'b0; host_req = 1'b0; prog_loc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic start_frame(input int L);
      @(negedge clk);
      frame_start = 1'b1; prog_loc = 5'(L);
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   // one pass with halt at word index off; optional loc change mid-pass
   task automatic run_pass(input int L, input int off, input int new_loc, input string rq);
      logic [15:0] base;
      int e_f, e_r, e_e;
      longint a_f, x_f, a_r, x_r, a_e;
      e_f = 0; e_r = 0; e_e = 0; a_f = 0; x_f = 0; a_r = 0; x_r = 0; a_e = 0;
      base = 16'(L * 1024);
      halt_a = 16'(base + 2 * off);
      start_frame(L);
      for (int k = 1; k <= off + 3; k++) begin
         int f, n;
         if (k > 1) @(negedge clk);
         f = k - 1; n = k - 2;
         if (f <= off + 1 && f < 1024) begin
            if (!(flash_req && flash_addr == 16'(base + 2 * f) && busy)) begin
               if (e_f == 0) begin a_f = flash_addr; x_f = 16'(base + 2 * f); end
               e_f++;
            end
         end
         if (n >= 0 && n <= off) begin
            if (!(instr_valid && instr_pc == 10'(n) &&
                  instr_word == word_at(16'(base + 2 * n)) && pass_done == (n == off))) begin
               if (e_r == 0) begin a_r = {instr_valid, pass_done, instr_pc, instr_word}; x_r = n; end
               e_r++;
            end
         end
         if (k == off + 3) begin
            if (busy || instr_valid || pass_done || flash_req) begin
               a_e = {busy, instr_valid, pass_done, flash_req}; e_e++;
            end
         end
         if (k == 2 && new_loc >= 0) prog_loc = 5'(new_loc);
      end
      chk(e_f == 0, rq, "fetch address sequence (R2/R3/R4)", a_f, x_f);
      chk(e_r == 0, rq, "presented words and halt pulse (R3/R5)", a_r, x_r);
      chk(e_e == 0, rq, "idle after halt (R5)", a_e, 0);
   endtask

   // {loc[4:0], halt offset[10:0]}
   localparam logic [15:0] VEC [8] = '{
      {5'd0,  11'd0},   {5'd1,  11'd3},   {5'd31, 11'd10},  {5'd7,  11'd511},
      {5'd5,  11'd600}, {5'd16, 11'd1},   {5'd2,  11'd1023}, {5'd30, 11'd100}
   };

   initial begin
      do_reset();
      // R1 reset state
      chk(!busy && !pass_done && !instr_valid, "R1", "pass outputs after reset",
          {busy, pass_done, instr_valid}, 0);
      chk(!overrun && !limit_err && !host_rvalid, "R1", "flags after reset",
          {overrun, limit_err, host_rvalid}, 0);
      chk(!flash_req, "R1", "no flash strobe when idle", flash_req, 0);

      // R8/R9 host served at once while idle
      @(negedge clk);
      host_req = 1'b1; host_addr = 16'h1234;
      #0;
      chk(host_ready && flash_addr == 16'h1234, "R8", "idle host grant",
          {host_ready, flash_addr}, {1'b1, 16'h1234});
      @(negedge clk);
      host_req = 1'b0;
      chk(host_rvalid && host_rdata == word_at(16'h1234), "R9", "host read data",
          host_rdata, word_at(16'h1234));
      @(negedge clk);
      chk(!host_rvalid, "R9", "rvalid single cycle", host_rvalid, 0);

      // table of passes: R2 R3 R5 (and R6 boundary at word 1023)
      for (int i = 0; i < 8; i++) begin
         run_pass(int'(VEC[i][15:11]), int'(VEC[i][10:0]), -1, "R2_R3_R5");
         chk(!limit_err && !overrun, "R6", "normal pass leaves flags clear",
             {limit_err, overrun}, 0);
      end

      // R4 location change mid-pass is ignored
      run_pass(3, 8, 9, "R4");

      // R8 host waits through a pass
      begin
         int first_ok;
         first_ok = -1;
         halt_a = 16'(2 * 1024 + 2 * 5);
         start_frame(2);
         host_req = 1'b1; host_addr = 16'h0100;
         for (int k = 1; k <= 9; k++) begin
            if (k > 1) @(negedge clk);
            if (host_ready && first_ok < 0) first_ok = k;
         end
         chk(first_ok == 8, "R8", "host first grant cycle after halt", first_ok, 8);
         @(negedge clk);
         host_req = 1'b0;
      end

      // R6 limit without halt
      do_reset();
      begin
         int nf, ni, nd;
         logic [15:0] last;
         nf = 0; ni = 0; nd = 0; last = '0;
         halt_a = 16'hFFFF;
         start_frame(1);
         for (int c = 0; c < 1040; c++) begin
            if (c > 0) @(negedge clk);
            if (flash_req) begin nf++; last = flash_addr; end
            if (instr_valid) ni++;
            if (pass_done) nd++;
         end
         chk(nf == 1024, "R6", "fetch count at limit", nf, 1024);
         chk(ni == 1024 && nd == 0, "R6", "words presented at limit", ni, 1024);
         chk(last == 16'(1024 + 2046), "R6", "last fetch address", last, 1024 + 2046);
         chk(limit_err && !busy, "R6", "limit error raised, pass stopped",
             {limit_err, busy}, 2'b10);
         chk(!overrun, "R7", "no overrun from limit stop", overrun, 0);
      end
      run_pass(0, 2, -1, "R6");
      chk(limit_err && !overrun, "R7", "idle start keeps overrun low, limit sticky",
          {limit_err, overrun}, 2'b10);

      // R7 overrun restart
      do_reset();
      halt_a = 16'(6 * 1024 + 4);
      start_frame(4);
      repeat (9) @(negedge clk);
      chk(busy && !overrun, "R7", "pass running before second start",
          {busy, overrun}, 2'b10);
      frame_start = 1'b1; prog_loc = 5'd6;
      @(negedge clk);
      frame_start = 1'b0;
      chk(overrun && !instr_valid && flash_addr == 16'(6 * 1024), "R7",
          "restart at new base, in-flight word dropped",
          {overrun, instr_valid, flash_addr}, {2'b10, 16'(6 * 1024)});
      begin
         int e;
         e = 0;
         for (int n = 0; n <= 2; n++) begin
            @(negedge clk);
            if (!(instr_valid && instr_pc == 10'(n) && pass_done == (n == 2))) e++;
         end
         chk(e == 0, "R7", "restarted pass words", e, 0);
      end
      repeat (20) @(negedge clk);
      chk(overrun && !busy, "R7", "overrun sticky after pass", {overrun, busy}, 2'b10);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule